// File: doc/BRIEF.md
# Exception Entry and Fault Capture Unit

This unit sits at the point where a processor pipeline takes a fault. It gets one fault request per cycle. The request carries a fault-type code, the program counter of the faulting instruction, the faulting virtual address, the instruction word, the memory access flags, and two qualifiers that mark a page-table-entry load and a prefetch. From these the unit computes the entry PC of the privileged handler and sends it to the fetch stage as a one-cycle redirect. In the same step it records the fault state that the handler will later read.

The fault state is held in a set of registers: the restart (exception) address, the data fault address, a packed memory-management status word, two formatted page-table-entry addresses (one for the data side, one for the instruction side) and the instruction-TLB tag. Software writes three base registers: the handler base and the data and instruction page-table bases. A saturating event counter for each fault type records how often that type has been taken, and a select input reads the counters out. Arithmetic traps are not handled here. They are reported on an error output.

Top module: `exc_entry_unit`

## Requirements
- R1: Fault codes and handler offsets: 0 reset 0x0001, 1 interrupt 0x0101, 2 instruction access violation 0x0081, 3 instruction TLB miss 0x0181, 4 single data TLB miss 0x0201, 5 double data TLB miss 0x0281, 6 unaligned 0x0301, 7 data page fault 0x0381, 8 data access violation 0x0381, 9 machine check 0x0401, 10 illegal opcode 0x0481, 11 arithmetic 0x0501, 12 integer overflow 0x0501, 13 float disabled 0x0581, 14 privileged call 0x2001.
- R2: `redirect_pc` equals the handler base plus the offset of the fault type. The handler base used is the value held before any software write made in the same cycle.
- R3: `redirect_vld` rises in the cycle after an accepted request (codes 0 to 10 and 12 to 14) and stays high for exactly one cycle, unless another request follows.
- R4: `exc_addr` takes the fault PC when the type is reset, interrupt or machine check, or when PC bits [1:0] are both zero. In every other case it keeps its value.
- R5: For integer overflow and privileged call, `exc_addr` is 4 more than the value that the R4 rule gives.
- R6: For data-side types (codes 4, 5, 7 and 8), the data fault address, the status word and the data formatted address update only when neither `fault_pte_ld` nor `fault_prefetch` is set. No other type changes them.
- R7: `mm_status` is {instruction[31:26], instruction[25:21], access flags[5:0]}. The opcode sits in bits 16:11, Ra in bits 10:6 and the flags in bits 5:0.
- R8: `dva_form` equals the data page-table base ORed with (VA[42:13] << 3).
- R9: For codes 2 and 3, `itb_tag` takes the fault PC and `iva_form` takes the instruction page-table base ORed with (PC[42:13] << 3). No other type changes them.
- R10: Each accepted or arithmetic request increments the counter of its type, and the counter saturates at 2^CNT_W-1. `cnt_rd_value` shows the counter that `cnt_rd_sel` selects, and reads 0 for select 15.
- R11: An arithmetic request (code 11) raises `unsup_err` for one cycle. It gives no redirect and changes no capture register.
- R12: Code 15 is ignored: no redirect, no error, no register or counter change.
- R13: Software write select: 0 handler base, 1 data page-table base, 2 instruction page-table base, 3 ignored. After reset every register and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_vld | input | 1 | Fault request strobe |
| fault_code | input | 4 | Fault type code |
| fault_pc | input | PC_W | PC of faulting instruction |
| fault_va | input | VA_W | Faulting data virtual address |
| fault_inst | input | 32 | Faulting instruction word |
| fault_acc | input | 6 | Memory access flags |
| fault_pte_ld | input | 1 | Request was a page-table-entry load |
| fault_prefetch | input | 1 | Request was a prefetch |
| csr_wr_en | input | 1 | Base register write strobe |
| csr_wr_sel | input | 2 | Base register select |
| csr_wr_data | input | PC_W | Base register write data |
| cnt_rd_sel | input | 4 | Event counter select |
| redirect_vld | output | 1 | Redirect strobe |
| redirect_pc | output | PC_W | Handler entry PC |
| unsup_err | output | 1 | Arithmetic trap not supported |
| exc_addr | output | PC_W | Restart address |
| dfault_va | output | VA_W | Captured data fault address |
| mm_status | output | 17 | Packed memory-management status |
| dva_form | output | PC_W | Data formatted page-table-entry address |
| iva_form | output | PC_W | Instruction formatted page-table-entry address |
| itb_tag | output | PC_W | Instruction TLB tag |
| cnt_rd_value | output | CNT_W | Selected event counter |

## Verification
The bench sweeps every fault code against every combination of the two low PC bits and of the page-table-load and prefetch qualifiers. A design that decoded the force or skip sets wrongly would leave a stale restart address, or put one off by 4, on the misaligned rows. A design that ignored the qualifiers would overwrite the data fault address on page-table-entry loads. Shared vectors are checked at codes 7/8 and 11/12. Code 11 must not redirect, and code 15 must have no effect at all. A write to the handler base in the same cycle as a fault must not affect the redirect target. The counters are read after one pass and again after saturating passes, so a counter that wraps would read a small value in place of the maximum.

// File: rtl/fcu_pkg.sv
// Package: fault codes and per-type attribute table of the exception entry unit.
// Assumes a 4-bit code space in which code 15 is not a fault.
package fcu_pkg;

    typedef enum logic [3:0] {
        FT_RESET    = 4'd0,
        FT_INTR     = 4'd1,
        FT_IACV     = 4'd2,
        FT_IMISS    = 4'd3,
        FT_DMISS1   = 4'd4,
        FT_DMISS2   = 4'd5,
        FT_UNALIGN  = 4'd6,
        FT_DPAGE    = 4'd7,
        FT_DACV     = 4'd8,
        FT_MCHK     = 4'd9,
        FT_OPDEC    = 4'd10,
        FT_ARITH    = 4'd11,
        FT_INTOVF   = 4'd12,
        FT_FPDIS    = 4'd13,
        FT_PRIVCALL = 4'd14,
        FT_NONE     = 4'd15
    } fault_e;

    localparam int NUM_TYPES = 15;
    localparam int OFFS_W    = 14;
    localparam int MMST_W    = 17;

    typedef struct packed {
        logic [OFFS_W-1:0] offset;
        logic              known;
        logic              force_rst;
        logic              skip;
        logic              data_side;
        logic              instr_side;
        logic              unsupported;
    } fault_attr_t;

    // Returns the handler offset and behaviour flags for a fault code.
    function automatic fault_attr_t attr_of(input logic [3:0] code);
        fault_attr_t a;
        a = '0;
        a.known = 1'b1;
        case (fault_e'(code))
            FT_RESET:    begin a.offset = 14'h0001; a.force_rst = 1'b1; end
            FT_INTR:     begin a.offset = 14'h0101; a.force_rst = 1'b1; end
            FT_IACV:     begin a.offset = 14'h0081; a.instr_side = 1'b1; end
            FT_IMISS:    begin a.offset = 14'h0181; a.instr_side = 1'b1; end
            FT_DMISS1:   begin a.offset = 14'h0201; a.data_side = 1'b1; end
            FT_DMISS2:   begin a.offset = 14'h0281; a.data_side = 1'b1; end
            FT_UNALIGN:  a.offset = 14'h0301;
            FT_DPAGE:    begin a.offset = 14'h0381; a.data_side = 1'b1; end
            FT_DACV:     begin a.offset = 14'h0381; a.data_side = 1'b1; end
            FT_MCHK:     begin a.offset = 14'h0401; a.force_rst = 1'b1; end
            FT_OPDEC:    a.offset = 14'h0481;
            FT_ARITH:    begin a.offset = 14'h0501; a.unsupported = 1'b1; end
            FT_INTOVF:   begin a.offset = 14'h0501; a.skip = 1'b1; end
            FT_FPDIS:    a.offset = 14'h0581;
            FT_PRIVCALL: begin a.offset = 14'h2001; a.skip = 1'b1; end
            default:     a.known = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/fcu_vec_decode.sv
// Vector decode: turns the fault code into attributes and the handler target PC.
// Purely combinational. The caller registers the target.
module fcu_vec_decode
    import fcu_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic [3:0]      code,
    input  logic [PC_W-1:0] handler_base,
    output fault_attr_t     attr,
    output logic [PC_W-1:0] target_pc
);

    // Table lookup followed by the base-plus-offset sum.
    always_comb begin
        attr      = attr_of(code);
        target_pc = handler_base + PC_W'(attr.offset);
    end

endmodule

// File: rtl/fcu_capture.sv
// Capture registers: restart address, data fault state, instruction TLB state
// and the three software-written base registers. Assumes PC_W >= VA_W and an
// 8 KB page.
module fcu_capture
    import fcu_pkg::*;
#(
    parameter int PC_W     = 64,
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  fault_attr_t       attr,
    input  logic [PC_W-1:0]   pc,
    input  logic [VA_W-1:0]   va,
    input  logic [31:0]       inst,
    input  logic [5:0]        acc,
    input  logic              pte_ld,
    input  logic              prefetch,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PC_W-1:0]   wr_data,
    output logic [PC_W-1:0]   handler_base,
    output logic [PC_W-1:0]   exc_addr,
    output logic [VA_W-1:0]   dfault_va,
    output logic [MMST_W-1:0] mm_status,
    output logic [PC_W-1:0]   dva_form,
    output logic [PC_W-1:0]   iva_form,
    output logic [PC_W-1:0]   itb_tag
);

    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PAD_W = PC_W - VPN_W - 3;

    logic [PC_W-1:0]  dptb_q, iptb_q;
    logic [PC_W-1:0]  exc_sel, exc_next;
    logic [VPN_W-1:0] dvpn, ivpn;
    logic             dcap, icap;

    // Restart address: capture rule first, then the optional skip of 4.
    always_comb begin
        exc_sel  = (attr.force_rst || pc[1:0] == 2'b00) ? pc : exc_addr;
        exc_next = attr.skip ? exc_sel + PC_W'(4) : exc_sel;
    end

    // Qualify the data-side and instruction-side capture enables.
    always_comb begin
        dcap = take && attr.data_side && !pte_ld && !prefetch;
        icap = take && attr.instr_side;
        dvpn = va[VA_W-1:PG_SHIFT];
        ivpn = pc[VA_W-1:PG_SHIFT];
    end

    // Software-written base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_base <= '0;
            dptb_q       <= '0;
            iptb_q       <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                2'd0:    handler_base <= wr_data;
                2'd1:    dptb_q       <= wr_data;
                2'd2:    iptb_q       <= wr_data;
                default: ;
            endcase
        end
    end

    // Restart address register.
    always_ff @(posedge clk) begin
        if (!rst_n)    exc_addr <= '0;
        else if (take) exc_addr <= exc_next;
    end

    // Data fault address, status word and data formatted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfault_va <= '0;
            mm_status <= '0;
            dva_form  <= '0;
        end else if (dcap) begin
            dfault_va <= va;
            mm_status <= {inst[31:26], inst[25:21], acc};
            dva_form  <= dptb_q | {{PAD_W{1'b0}}, dvpn, 3'b000};
        end
    end

    // Instruction TLB tag and instruction formatted address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            itb_tag  <= '0;
            iva_form <= '0;
        end else if (icap) begin
            itb_tag  <= pc;
            iva_form <= iptb_q | {{PAD_W{1'b0}}, ivpn, 3'b000};
        end
    end

    AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(exc_addr)) else $error("exc_addr moved without a fault"); // R4
    AST_PTE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (pte_ld || prefetch)) |=> $stable(dfault_va) && $stable(mm_status)) else $error("data state captured on pte/prefetch"); // R6
    AST_ITAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && attr.instr_side) |=> $stable(itb_tag)) else $error("itb_tag moved"); // R9

endmodule

// File: rtl/fcu_event_counters.sv
// Event counters: one saturating counter per fault type, with a read mux.
// Assumes NTYPES < 16, so select 15 always reads 0.
module fcu_event_counters #(
    parameter int NTYPES = 15,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_vld,
    input  logic [3:0]       inc_code,
    input  logic [3:0]       rd_sel,
    output logic [CNT_W-1:0] rd_value
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [NTYPES];

    for (genvar i = 0; i < NTYPES; i++) begin : g_cnt
        // Count events of type i and stop at the maximum.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[i] <= '0;
            else if (inc_vld && inc_code == 4'(i) && cnt_q[i] != CNT_MAX)
                cnt_q[i] <= cnt_q[i] + 1'b1;
        end

        AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == CNT_MAX) |=> (cnt_q[i] == CNT_MAX)) else $error("counter wrapped"); // R10
    end

    // Read mux. Out-of-range selects give zero.
    always_comb begin
        rd_value = '0;
        for (int k = 0; k < NTYPES; k++)
            if (rd_sel == 4'(k)) rd_value = cnt_q[k];
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Exception entry unit top. Decodes a fault request, registers the handler
// redirect, updates the capture registers and counts events. Assumes at most
// one fault request per cycle.
module exc_entry_unit
    import fcu_pkg::*;
#(
    parameter int PC_W     = 64,
    parameter int VA_W     = 43,
    parameter int PG_SHIFT = 13,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_vld,
    input  logic [3:0]        fault_code,
    input  logic [PC_W-1:0]   fault_pc,
    input  logic [VA_W-1:0]   fault_va,
    input  logic [31:0]       fault_inst,
    input  logic [5:0]        fault_acc,
    input  logic              fault_pte_ld,
    input  logic              fault_prefetch,
    input  logic              csr_wr_en,
    input  logic [1:0]        csr_wr_sel,
    input  logic [PC_W-1:0]   csr_wr_data,
    input  logic [3:0]        cnt_rd_sel,
    output logic              redirect_vld,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              unsup_err,
    output logic [PC_W-1:0]   exc_addr,
    output logic [VA_W-1:0]   dfault_va,
    output logic [16:0]       mm_status,
    output logic [PC_W-1:0]   dva_form,
    output logic [PC_W-1:0]   iva_form,
    output logic [PC_W-1:0]   itb_tag,
    output logic [CNT_W-1:0]  cnt_rd_value
);

    fault_attr_t     attr;
    logic [PC_W-1:0] target_pc;
    logic [PC_W-1:0] handler_base;
    logic            take, unsup, counted;

    fcu_vec_decode #(.PC_W(PC_W)) u_dec (
        .code         (fault_code),
        .handler_base (handler_base),
        .attr         (attr),
        .target_pc    (target_pc)
    );

    // Classify the request: taken, unsupported or ignored.
    always_comb begin
        take    = fault_vld && attr.known && !attr.unsupported;
        unsup   = fault_vld && attr.known && attr.unsupported;
        counted = fault_vld && attr.known;
    end

    fcu_capture #(.PC_W(PC_W), .VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .attr         (attr),
        .pc           (fault_pc),
        .va           (fault_va),
        .inst         (fault_inst),
        .acc          (fault_acc),
        .pte_ld       (fault_pte_ld),
        .prefetch     (fault_prefetch),
        .wr_en        (csr_wr_en),
        .wr_sel       (csr_wr_sel),
        .wr_data      (csr_wr_data),
        .handler_base (handler_base),
        .exc_addr     (exc_addr),
        .dfault_va    (dfault_va),
        .mm_status    (mm_status),
        .dva_form     (dva_form),
        .iva_form     (iva_form),
        .itb_tag      (itb_tag)
    );

    fcu_event_counters #(.NTYPES(NUM_TYPES), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_vld  (counted),
        .inc_code (fault_code),
        .rd_sel   (cnt_rd_sel),
        .rd_value (cnt_rd_value)
    );

    // Register the redirect and error strobes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
            unsup_err    <= 1'b0;
        end else begin
            redirect_vld <= take;
            unsup_err    <= unsup;
            if (take) redirect_pc <= target_pc;
        end
    end

    AST_REDIR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> $past(fault_vld)) else $error("redirect without request"); // R3
    AST_ERR_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_vld && unsup_err)) else $error("redirect on arithmetic trap"); // R11
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && fault_code == 4'd15) |=> !redirect_vld && !unsup_err && $stable(exc_addr)) else $error("code 15 acted"); // R12

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 64, VA_W = 43, CNT_W = 4;

    logic clk = 0, rst_n = 0;
    logic fault_vld = 0, fault_pte_ld = 0, fault_prefetch = 0, csr_wr_en = 0;
    logic [3:0] fault_code = 0, cnt_rd_sel = 0;
    logic [PC_W-1:0] fault_pc = 0, csr_wr_data = 0;
    logic [VA_W-1:0] fault_va = 0;
    logic [31:0] fault_inst = 0;
    logic [5:0] fault_acc = 0;
    logic [1:0] csr_wr_sel = 0;
    logic redirect_vld, unsup_err;
    logic [PC_W-1:0] redirect_pc, exc_addr, dva_form, iva_form, itb_tag;
    logic [VA_W-1:0] dfault_va;
    logic [16:0] mm_status;
    logic [CNT_W-1:0] cnt_rd_value;

    int checks = 0, failures = 0;
    logic [PC_W-1:0] m_hb = 0, m_dptb = 0, m_iptb = 0, m_exc = 0, m_dform = 0, m_iform = 0, m_tag = 0;
    logic [VA_W-1:0] m_va = 0;
    logic [16:0] m_mm = 0;
    int m_cnt [16];

    exc_entry_unit u_exc_entry_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] offs(input int c);
        case (c)
            0: return 14'h0001;  1: return 14'h0101;  2: return 14'h0081;
            3: return 14'h0181;  4: return 14'h0201;  5: return 14'h0281;
            6: return 14'h0301;  7: return 14'h0381;  8: return 14'h0381;
            9: return 14'h0401; 10: return 14'h0481; 11: return 14'h0501;
            12: return 14'h0501; 13: return 14'h0581; 14: return 14'h2001;
            default: return 14'h0000;
        endcase
    endfunction

    task automatic csr_write(input logic [1:0] sel, input logic [PC_W-1:0] d);
        @(negedge clk);
        csr_wr_en = 1; csr_wr_sel = sel; csr_wr_data = d;
        @(negedge clk);
        csr_wr_en = 0;
        if (sel == 0) m_hb = d; else if (sel == 1) m_dptb = d; else if (sel == 2) m_iptb = d;
    endtask

    // One fault request, model update and checks (R1-R12 tags in messages).
    task automatic fire(input int c, input logic [PC_W-1:0] pc, input logic [VA_W-1:0] va,
                        input logic [31:0] inst, input logic [5:0] acc, input logic pte, input logic pf);
        bit taken, force_r, skip, dside, iside;
        logic [PC_W-1:0] exp_pc;
        taken   = (c <= 14) && (c != 11);
        force_r = (c == 0) || (c == 1) || (c == 9);
        skip    = (c == 12) || (c == 14);
        dside   = (c == 4) || (c == 5) || (c == 7) || (c == 8);
        iside   = (c == 2) || (c == 3);
        exp_pc  = m_hb + 64'(offs(c));
        @(negedge clk);
        fault_vld = 1; fault_code = 4'(c); fault_pc = pc; fault_va = va;
        fault_inst = inst; fault_acc = acc; fault_pte_ld = pte; fault_prefetch = pf;
        @(negedge clk);
        fault_vld = 0;
        if (taken) begin
            if (force_r || pc[1:0] == 2'b00) m_exc = pc;
            if (skip) m_exc = m_exc + 4;
            if (dside && !pte && !pf) begin
                m_va = va;
                m_mm = {inst[31:26], inst[25:21], acc};
                m_dform = m_dptb | {21'd0, va[42:13], 3'b000};
            end
            if (iside) begin
                m_tag = pc;
                m_iform = m_iptb | {21'd0, pc[42:13], 3'b000};
            end
        end
        if (c <= 14) m_cnt[c] = (m_cnt[c] == 15) ? 15 : m_cnt[c] + 1;
        chk($sformatf("R3 redirect_vld code %0d", c), 64'(redirect_vld), 64'(taken));
        if (taken) chk($sformatf("R1 R2 redirect_pc code %0d", c), redirect_pc, exp_pc);
        chk($sformatf("R11 R12 unsup_err code %0d", c), 64'(unsup_err), 64'(c == 11));
        chk($sformatf("R4 R5 exc_addr code %0d pc %h", c, pc), exc_addr, m_exc);
        chk($sformatf("R6 dfault_va code %0d pte %0d pf %0d", c, pte, pf), 64'(dfault_va), 64'(m_va));
        chk($sformatf("R7 mm_status code %0d", c), 64'(mm_status), 64'(m_mm));
        chk($sformatf("R8 dva_form code %0d", c), dva_form, m_dform);
        chk($sformatf("R9 itb_tag code %0d", c), itb_tag, m_tag);
        chk($sformatf("R9 iva_form code %0d", c), iva_form, m_iform);
        @(negedge clk);
        chk($sformatf("R3 one-cycle strobe code %0d", c), 64'({redirect_vld, unsup_err}), 64'(0));
    endtask

    task automatic check_counters(input string tag);
        for (int s = 0; s < 16; s++) begin
            cnt_rd_sel = 4'(s);
            #1;
            chk($sformatf("%s counter %0d", tag, s), 64'(cnt_rd_value), 64'(s == 15 ? 0 : m_cnt[s]));
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset redirect", 64'({redirect_vld, unsup_err}), 64'(0));
        chk("R13 reset exc_addr", exc_addr, 64'(0));
        chk("R13 reset forms", dva_form | iva_form | itb_tag | redirect_pc, 64'(0));
        chk("R13 reset status", 64'(mm_status) | 64'(dfault_va), 64'(0));
        check_counters("R13 R10 reset");
        // R13 base writes, select 3 ignored
        csr_write(2'd0, 64'h0000_0000_1000_0000);
        csr_write(2'd1, 64'h0000_0001_2345_6FF8);
        csr_write(2'd2, 64'h0000_00F0_0000_0FF8);
        csr_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        // one pass per code
        for (int c = 0; c < 16; c++)
            fire(c, 64'h0000_0123_4567_8000 + 64'(c * 8200), 43'h512_3456_7000 + 43'(c * 8192),
                 32'hA5C3_0000 ^ 32'(c << 21), 6'(c + 5), 0, 0);
        check_counters("R10 single pass");
        // R2: handler base write in the same cycle as a fault uses the old base
        @(negedge clk);
        fault_vld = 1; fault_code = 4'd10; fault_pc = 64'h40; fault_va = '0;
        fault_pte_ld = 0; fault_prefetch = 0;
        csr_wr_en = 1; csr_wr_sel = 0; csr_wr_data = 64'h0000_0000_2000_0000;
        @(negedge clk);
        fault_vld = 0; csr_wr_en = 0;
        chk("R2 same-cycle base write", redirect_pc, m_hb + 64'h0481);
        m_hb = 64'h0000_0000_2000_0000; m_exc = 64'h40;
        m_cnt[10] = (m_cnt[10] == 15) ? 15 : m_cnt[10] + 1;
        // sweep: code x low PC bits x qualifiers
        for (int c = 0; c < 16; c++)
            for (int lo = 0; lo < 4; lo++)
                for (int q = 0; q < 4; q++)
                    fire(c, 64'h0000_0456_789A_0000 + 64'(c * 40960 + q * 16) + 64'(lo),
                         43'h3AB_CDEF_0000 + 43'((c * 16 + lo * 4 + q) * 8192) + 43'(q),
                         32'h0000_1234 | 32'((c + q) << 21) | 32'(lo << 26), 6'(c * 3 + q), q[0], q[1]);
        check_counters("R10 saturated");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule